// File: doc/BRIEF.md
# Wavetable Channel Sample Sequencer

This block produces the read position into a 32-entry waveform for one sound channel. While the channel runs, a period down-counter steps the 5-bit sample index forward once every 4 × (2048 − F) input clocks, where F is the 11-bit frequency word. The index wraps from 31 back to 0. The waveform memory, the volume and the mixer sit outside the block and use the index and the running flag that it drives.

The channel starts when the enable input rises while the channel is idle. At that moment the index clears to 0, the period counter clears to 0 and the length timer loads its start value. When auto-stop is set, the length timer counts down on every running cycle. When it is already at zero on a running cycle, the channel turns itself off. After that the enable input must fall and rise again before the channel restarts. Dropping the enable input stops the channel at once, and every counter freezes.

Top module: `wave_step_seq`

## Requirements
- R1: While running, the index advances every 4 × (2048 − F) clocks. F is sampled at the moment the period counter reloads.
- R2: Each advance adds one to the 5-bit index, modulo 32, so 31 is followed by 0.
- R3: With auto-stop set and a length value L loaded at start, the running flag is high on the L+1 clock edges after the start edge (counting the start edge itself) and drops on the edge after those.
- R4: While the running flag is low, the index holds its value and no counter moves.
- R5: The period counter is zero after reset and after each start, so the first running edge after the start edge advances the index to 1.
- R6: The length timer counts down only on running edges with auto-stop set. With auto-stop clear, the channel never stops by itself and the timer keeps its count.
- R7: A start edge sets the running flag and clears the index to 0.
- R8: A new F does not shorten or restart the period in progress. It sets the length of the next period.
- R9: After reset the index is 0 and the running flag is low.
- R10: After an auto-stop, the channel stays off while enable is held high. It restarts only after enable falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en_i | input | 1 | Channel enable level; a rise while idle starts the channel |
| freq_i | input | 11 | Frequency word F |
| auto_stop_i | input | 1 | Lets the length timer stop the channel |
| len_i | input | 8 | Length timer start value, loaded on a start edge |
| sample_idx_o | output | 5 | Current waveform sample index |
| chan_on_o | output | 1 | Channel running flag |

## Verification
Both outputs are registered, so each result is visible one edge after the edge that causes it. The running flag and the cleared index show one edge after enable is sampled high. The first advance comes one edge later, and each further advance comes a full period after the previous one. An auto-stop shows on the edge L+1 edges after the start edge. The bench drives and samples on falling edges and counts rising edges from a known start edge to each expected change. For every timing point it checks both the cycle just before the change and the change itself.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_SPENT = 2'd2
  } ch_state_e;
endpackage

// File: rtl/wss_period_timer.sv
module wss_period_timer #(
  parameter int FREQ_W = 11,
  parameter int MUL_SH = 2,
  localparam int PER_W = FREQ_W + MUL_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              active,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              step_o,
  output logic [PER_W-1:0]  cnt_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] reload;

  // (2^FREQ_W - F) * 2^MUL_SH - 1 equals ((2^FREQ_W - 1 - F) << MUL_SH) | ones
  assign reload = {~freq_i, {MUL_SH{1'b1}}};
  assign step_o = active && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (active) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wss_len_timer.sv
module wss_len_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             tick,
  output logic             zero_o,
  output logic [LEN_W-1:0] cnt_o
);
  logic [LEN_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wss_index_ctr.sv
module wss_index_ctr #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  assign idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear) idx_q <= '0;
    else if (step)    idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/wave_step_seq.sv
module wave_step_seq #(
  parameter int FREQ_W = 11,
  parameter int MUL_SH = 2,
  parameter int IDX_W  = 5,
  parameter int LEN_W  = 8,
  localparam int PER_W = FREQ_W + MUL_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              auto_stop_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [IDX_W-1:0]  sample_idx_o,
  output logic              chan_on_o
);
  import wss_pkg::*;

  ch_state_e        state_q;
  logic             start;
  logic             run;
  logic             stop_now;
  logic             active;
  logic             step;
  logic             len_zero;
  logic [LEN_W-1:0] len_cnt;
  logic [PER_W-1:0] per_cnt;

  assign start     = (state_q == CH_IDLE) && chan_en_i;
  assign run       = (state_q == CH_RUN) && chan_en_i;
  assign stop_now  = run && auto_stop_i && len_zero;
  assign active    = run && !stop_now;
  assign chan_on_o = (state_q == CH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
    end else begin
      unique case (state_q)
        CH_IDLE:  if (chan_en_i) state_q <= CH_RUN;
        CH_RUN:   if (!chan_en_i) state_q <= CH_IDLE;
                  else if (stop_now) state_q <= CH_SPENT;
        CH_SPENT: if (!chan_en_i) state_q <= CH_IDLE;
        default:  state_q <= CH_IDLE;
      endcase
    end
  end

  wss_period_timer #(.FREQ_W(FREQ_W), .MUL_SH(MUL_SH)) u_period (
    .clk(clk), .rst(rst), .restart(start), .active(active),
    .freq_i(freq_i), .step_o(step), .cnt_o(per_cnt)
  );

  wss_len_timer #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .load(start), .load_val(len_i),
    .tick(active && auto_stop_i), .zero_o(len_zero), .cnt_o(len_cnt)
  );

  wss_index_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .clear(start), .step(step), .idx_o(sample_idx_o)
  );
endmodule

// File: rtl/wss_checker.sv
module wss_checker #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 8,
  parameter int PER_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en_i,
  input logic             auto_stop_i,
  input logic             chan_on_o,
  input logic [IDX_W-1:0] sample_idx_o,
  input logic             start,
  input logic             step,
  input logic             len_zero,
  input logic [LEN_W-1:0] len_cnt,
  input logic [PER_W-1:0] per_cnt
);
  p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (chan_on_o && sample_idx_o == '0));

  p_step_adds_one_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> (sample_idx_o == IDX_W'($past(sample_idx_o) + 1'b1)));

  p_idle_holds_idx_r4: assert property (@(posedge clk) disable iff (rst)
    (!chan_on_o && !start) |=> $stable(sample_idx_o));

  p_idle_holds_period_r4: assert property (@(posedge clk) disable iff (rst)
    (!chan_on_o && !start) |=> $stable(per_cnt));

  p_no_step_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !chan_on_o |-> !step);

  p_expiry_stops_r3: assert property (@(posedge clk) disable iff (rst)
    (chan_on_o && chan_en_i && auto_stop_i && len_zero) |=> !chan_on_o);

  p_len_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (!auto_stop_i && !start) |=> $stable(len_cnt));

  p_first_step_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> (per_cnt == '0));
endmodule

bind wave_step_seq wss_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .chan_en_i(chan_en_i), .auto_stop_i(auto_stop_i),
  .chan_on_o(chan_on_o), .sample_idx_o(sample_idx_o), .start(start),
  .step(step), .len_zero(len_zero), .len_cnt(len_cnt), .per_cnt(per_cnt)
);

// File: tb/tb_wave_step_seq.sv
module tb_wave_step_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_en_i = 1'b0;
  logic [10:0] freq_i = 11'd2047;
  logic        auto_stop_i = 1'b0;
  logic [7:0]  len_i = 8'd0;
  logic [4:0]  sample_idx_o;
  logic        chan_on_o;

  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  wave_step_seq dut (
    .clk(clk), .rst(rst), .chan_en_i(chan_en_i), .freq_i(freq_i),
    .auto_stop_i(auto_stop_i), .len_i(len_i),
    .sample_idx_o(sample_idx_o), .chan_on_o(chan_on_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // enable set at a falling edge; returns after the start edge
  task automatic start_chan(input logic [10:0] f, input logic au, input logic [7:0] l);
    freq_i = f; auto_stop_i = au; len_i = l; chan_en_i = 1'b1;
    edges(1);
  endtask

  task automatic stop_chan();
    chan_en_i = 1'b0;
    edges(2);
  endtask

  task automatic t_reset();
    chk("R9 idx after reset", sample_idx_o, 0);
    chk("R9 running after reset", chan_on_o, 0);
  endtask

  task automatic t_period();
    start_chan(11'd2040, 1'b0, 8'd0);           // period 32
    chk("R7 running at start", chan_on_o, 1);
    chk("R7 idx at start", sample_idx_o, 0);
    edges(1);
    chk("R5 first step", sample_idx_o, 1);
    edges(31);
    chk("R1 before period end", sample_idx_o, 1);
    edges(1);
    chk("R1 at period end", sample_idx_o, 2);
    edges(32);
    chk("R1 second period", sample_idx_o, 3);
    stop_chan();
  endtask

  task automatic t_wrap();
    start_chan(11'd2047, 1'b0, 8'd0);           // period 4
    edges(1 + 30 * 4);
    chk("R2 idx 31", sample_idx_o, 31);
    edges(4);
    chk("R2 wrap to 0", sample_idx_o, 0);
    edges(4);
    chk("R2 after wrap", sample_idx_o, 1);
    stop_chan();
  endtask

  task automatic t_hold();
    int held;
    start_chan(11'd2047, 1'b0, 8'd0);
    edges(1 + 4);                                // idx 2
    held = sample_idx_o;
    chk("R4 idx before drop", held, 2);
    chan_en_i = 1'b0;
    edges(1);
    chk("R4 running cleared", chan_on_o, 0);
    edges(20);
    chk("R4 idx held while off", sample_idx_o, held);
    start_chan(11'd2047, 1'b0, 8'd0);
    chk("R7 restart clears idx", sample_idx_o, 0);
    stop_chan();
  endtask

  task automatic t_autostop();
    start_chan(11'd2047, 1'b1, 8'd5);
    edges(5);
    chk("R3 running after L edges", chan_on_o, 1);
    chk("R3 idx before stop", sample_idx_o, 2);
    edges(1);
    chk("R3 stopped", chan_on_o, 0);
    chk("R3 idx frozen on stop", sample_idx_o, 2);
    edges(10);
    chk("R10 stays off with enable high", chan_on_o, 0);
    chk("R4 idx held after stop", sample_idx_o, 2);
    chan_en_i = 1'b0;
    edges(1);
    start_chan(11'd2047, 1'b1, 8'd5);
    chk("R10 restart running", chan_on_o, 1);
    chk("R10 restart idx", sample_idx_o, 0);
    stop_chan();
  endtask

  task automatic t_auto_gate();
    start_chan(11'd2047, 1'b0, 8'd3);
    edges(20);
    chk("R6 no stop without auto", chan_on_o, 1);
    auto_stop_i = 1'b1;
    edges(3);
    chk("R6 count kept at 3", chan_on_o, 1);
    edges(1);
    chk("R6 stop after kept count", chan_on_o, 0);
    stop_chan();
    auto_stop_i = 1'b0;
  endtask

  task automatic t_freq_change();
    start_chan(11'd2047, 1'b0, 8'd0);
    edges(1);
    chk("R8 first step", sample_idx_o, 1);
    freq_i = 11'd2046;                           // period 8 from next reload
    edges(4);
    chk("R8 old period kept", sample_idx_o, 2);
    edges(7);
    chk("R8 new period not yet", sample_idx_o, 2);
    edges(1);
    chk("R8 new period applied", sample_idx_o, 3);
    stop_chan();
  endtask

  initial begin : watchdog
    #1500000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    edges(3);
    rst = 1'b0;
    edges(1);
    t_reset();
    t_period();
    t_wrap();
    t_hold();
    t_autostop();
    t_auto_gate();
    t_freq_change();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule